// File: doc/BRIEF.md
# Four-Channel Two-Phase DMA Engine

This block is a bus-master copy engine with four channels. Each channel owns a source pointer, a destination pointer, a control word and a transfer counter. Software programs these through a small word-indexed register port. Each transfer is split into two bus beats. The first beat reads the source into an internal holding register. The second beat writes that value to the destination. After each complete transfer, both pointers of the channel move by the unit size according to their own stepping modes, and the counter drops by one.

When several channels are ready at once, a fixed-priority arbiter picks one. A new choice is made only between whole transfers, so a read and its write are never split. A channel can be started by software or by a request line. Only the two lowest channels may take their request from the external request inputs. Each channel has a sticky completion flag that can raise a per-channel interrupt.

Top module: `dma4_engine`

## Requirements
- R1: Registers are addressed by word index `reg_idx` = 4*channel + slot. The slots are: 0 source pointer (byte offset 00h for channel 0), 1 destination pointer (04h), 2 control, 3 count. All four slots read back through `reg_rdata`. Control and count read 0 after reset.
- R2: Each transfer is a read beat at the source pointer (`m_write`=0), then a write beat at the destination pointer (`m_write`=1) carrying the value read. The write beat follows directly after the read beat is accepted.
- R3: Control bits 2:1 set the unit size: 00 byte, 01 halfword, 10 word. `m_size` carries this code on both beats. The written data keeps only the low 1, 2 or 4 bytes of the read data, and the rest is zero.
- R4: Control bits 4:3 (source) and 6:5 (destination) set the stepping mode: 00 fixed, 01 up by the unit size in bytes, 10 down by it, 11 fixed. The step is applied after each completed write beat.
- R5: The count register drops by one per completed transfer. When it reaches zero, the enable bit (control bit 0) clears and the done flag (control bit 16) sets.
- R6: `irq[n]` is high while channel n's done flag and its interrupt-enable bit (control bit 7) are both set. Writing 1 to control bit 16 clears the done flag.
- R7: Among eligible channels the lowest index is served first. Arbitration happens only after a write beat completes, so a transfer in flight is never pre-empted.
- R8: A channel is eligible when it is enabled, its count is non-zero, and either the software-start bit (control bit 8) is set or its request is high. Control bit 9 selects `ext_req` in place of `int_req`. On channels 2 and 3, bit 9 reads 0 and has no effect.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_addr`, `m_write` and `m_size` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| int_req | input | 4 | Internal request per channel |
| ext_req | input | 2 | External request, channels 0 and 1 |
| m_valid | output | 1 | Bus beat valid |
| m_ready | input | 1 | Bus beat accepted |
| m_write | output | 1 | Beat is a write |
| m_addr | output | 32 | Beat byte address |
| m_size | output | 2 | Unit size code |
| m_wdata | output | 32 | Write data |
| m_rdata | input | 32 | Read data, right-justified |
| irq | output | 4 | Per-channel completion interrupt |

## Verification
A word copy with both pointers stepping up checks whole-word data, final pointers and interrupt timing. A byte fill with a fixed source and a falling destination exposes sign errors in stepping and stray upper data bytes. A halfword run under bus stalls separates correct hold behaviour from beats that advance too early. A staggered multi-channel request pattern shows the difference between true fixed priority and pre-emption, and between re-arbitrating per transfer and per channel. Eligibility cases (external select, count zero, an ignored select bit) show which request source each channel actually listens to.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int DONE_BIT = 16;

  typedef enum logic [1:0] {SZ_BYTE = 2'b00, SZ_HALF = 2'b01, SZ_WORD = 2'b10, SZ_RSVD = 2'b11} xsize_e;
  typedef enum logic [1:0] {AM_FIX = 2'b00, AM_INC = 2'b01, AM_DEC = 2'b10, AM_HOLD = 2'b11} amode_e;

  // packed so that bit 0 is enable and bit 9 is the external-request select
  typedef struct packed {
    logic   extsel;
    logic   swtrig;
    logic   ie;
    amode_e dmode;
    amode_e smode;
    xsize_e size;
    logic   en;
  } chan_cfg_t;

  function automatic logic [2:0] size_bytes(input xsize_e s);
    case (s)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(input xsize_e s);
    case (s)
      SZ_BYTE: size_mask = 32'h0000_00FF;
      SZ_HALF: size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] next_addr(input logic [31:0] a, input amode_e m, input xsize_e s);
    case (m)
      AM_INC:  next_addr = a + {29'd0, size_bytes(s)};
      AM_DEC:  next_addr = a - {29'd0, size_bytes(s)};
      default: next_addr = a;
    endcase
  endfunction
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter bit EXT_OK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_slot,
  input  logic [31:0]      wdata,
  input  logic             int_req,
  input  logic             ext_req,
  input  logic             beat_done,
  output logic [31:0]      src_o,
  output logic [31:0]      dst_o,
  output chan_cfg_t        cfg_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o,
  output logic             elig_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  chan_cfg_t        cfg_q, cfg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [31:0]      src_q, src_d, dst_q, dst_d;
  logic             src_ce, dst_ce, src_wr, dst_wr;
  logic             sel_req;

  always_comb begin
    cfg_d  = cfg_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (wr_en && wr_slot == 2'd2) begin
      cfg_d = chan_cfg_t'(wdata[9:0]);
      if (!EXT_OK) cfg_d.extsel = 1'b0;
      if (wdata[DONE_BIT]) done_d = 1'b0;
    end
    if (wr_en && wr_slot == 2'd3) cnt_d = wdata[CNT_W-1:0];
    if (beat_done) begin
      cnt_d = cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) begin
        cfg_d.en = 1'b0;
        done_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // pointers have no reset value; loaded by software, stepped per transfer
  assign src_wr = wr_en && (wr_slot == 2'd0);
  assign dst_wr = wr_en && (wr_slot == 2'd1);
  assign src_ce = src_wr || beat_done;
  assign dst_ce = dst_wr || beat_done;

  always_comb begin
    src_d = src_wr ? wdata : next_addr(src_q, cfg_q.smode, cfg_q.size);
    dst_d = dst_wr ? wdata : next_addr(dst_q, cfg_q.dmode, cfg_q.size);
  end

  always_ff @(posedge clk) begin
    if (src_ce) src_q <= src_d;
    if (dst_ce) dst_q <= dst_d;
  end

  assign sel_req = cfg_q.extsel ? ext_req : int_req;
  assign elig_o  = cfg_q.en && (cnt_q != '0) && (cfg_q.swtrig || sel_req);
  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign cfg_o   = cfg_q;
  assign cnt_o   = cnt_q;
  assign done_o  = done_q;
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma4_xfer.sv
module dma4_xfer
  import dma4_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] gnt,
  input  logic [31:0]  src_sel,
  input  logic [31:0]  dst_sel,
  input  xsize_e       size_sel,
  input  logic         m_ready,
  input  logic [31:0]  m_rdata,
  output logic         m_valid,
  output logic         m_write,
  output logic [31:0]  m_addr,
  output logic [1:0]   m_size,
  output logic [31:0]  m_wdata,
  output logic [N-1:0] act_o,
  output logic [N-1:0] beat_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_e;

  st_e          st_q, st_d;
  logic [N-1:0] act_q, act_d;
  logic [31:0]  hold_q, hold_d;
  logic         hold_ce;

  always_comb begin
    st_d  = st_q;
    act_d = act_q;
    case (st_q)
      ST_IDLE: if (|gnt) begin
        st_d  = ST_RD;
        act_d = gnt;
      end
      ST_RD: if (m_ready) st_d = ST_WR;
      ST_WR: if (m_ready) begin
        st_d  = ST_IDLE;
        act_d = '0;
      end
      default: begin
        st_d  = ST_IDLE;
        act_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      act_q <= '0;
    end else begin
      st_q  <= st_d;
      act_q <= act_d;
    end
  end

  assign hold_ce = (st_q == ST_RD) && m_ready;
  assign hold_d  = m_rdata & size_mask(size_sel);

  always_ff @(posedge clk) begin
    if (hold_ce) hold_q <= hold_d;
  end

  assign m_valid = (st_q != ST_IDLE);
  assign m_write = (st_q == ST_WR);
  assign m_addr  = (st_q == ST_WR) ? dst_sel : src_sel;
  assign m_size  = size_sel;
  assign m_wdata = hold_q;
  assign act_o   = act_q;
  assign beat_o  = ((st_q == ST_WR) && m_ready) ? act_q : '0;
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma4_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NEXT  = 2,
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [$clog2(NCH)+1:0] reg_idx,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic [NCH-1:0]         int_req,
  input  logic [NEXT-1:0]        ext_req,
  output logic                   m_valid,
  input  logic                   m_ready,
  output logic                   m_write,
  output logic [31:0]            m_addr,
  output logic [1:0]             m_size,
  output logic [31:0]            m_wdata,
  input  logic [31:0]            m_rdata,
  output logic [NCH-1:0]         irq
);
  localparam int CH_W = $clog2(NCH);

  logic [1:0]       rst_sync;
  logic             rst_i;
  logic [31:0]      src_a [NCH];
  logic [31:0]      dst_a [NCH];
  chan_cfg_t        cfg_a [NCH];
  logic [CNT_W-1:0] cnt_a [NCH];
  logic [NCH-1:0]   done_v, elig_v, gnt_w, act_w, beat_w;
  logic [31:0]      src_sel, dst_sel;
  logic [1:0]       size_or;
  logic [CH_W-1:0]  rd_ch;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic ext_g, wr_g;
    if (g < NEXT) begin : g_ext
      assign ext_g = ext_req[g];
    end else begin : g_noext
      assign ext_g = 1'b0;
    end
    assign wr_g = reg_wr && (reg_idx[CH_W+1:2] == CH_W'(g));

    dma4_chan #(.CNT_W(CNT_W), .EXT_OK(g < NEXT)) u_chan (
      .clk      (clk),
      .rst_n    (rst_i),
      .wr_en    (wr_g),
      .wr_slot  (reg_idx[1:0]),
      .wdata    (reg_wdata),
      .int_req  (int_req[g]),
      .ext_req  (ext_g),
      .beat_done(beat_w[g]),
      .src_o    (src_a[g]),
      .dst_o    (dst_a[g]),
      .cfg_o    (cfg_a[g]),
      .cnt_o    (cnt_a[g]),
      .done_o   (done_v[g]),
      .elig_o   (elig_v[g])
    );
    assign irq[g] = done_v[g] && cfg_a[g].ie;
  end

  dma4_arb #(.N(NCH)) u_arb (
    .req(elig_v),
    .gnt(gnt_w)
  );

  always_comb begin
    src_sel = '0;
    dst_sel = '0;
    size_or = '0;
    for (int i = 0; i < NCH; i++) begin
      if (act_w[i]) begin
        src_sel = src_sel | src_a[i];
        dst_sel = dst_sel | dst_a[i];
        size_or = size_or | cfg_a[i].size;
      end
    end
  end

  dma4_xfer #(.N(NCH)) u_xfer (
    .clk     (clk),
    .rst_n   (rst_i),
    .gnt     (gnt_w),
    .src_sel (src_sel),
    .dst_sel (dst_sel),
    .size_sel(xsize_e'(size_or)),
    .m_ready (m_ready),
    .m_rdata (m_rdata),
    .m_valid (m_valid),
    .m_write (m_write),
    .m_addr  (m_addr),
    .m_size  (m_size),
    .m_wdata (m_wdata),
    .act_o   (act_w),
    .beat_o  (beat_w)
  );

  assign rd_ch = reg_idx[CH_W+1:2];

  always_comb begin
    case (reg_idx[1:0])
      2'd0:    reg_rdata = src_a[rd_ch];
      2'd1:    reg_rdata = dst_a[rd_ch];
      2'd2:    reg_rdata = {{(31-DONE_BIT){1'b0}}, done_v[rd_ch], {(DONE_BIT-10){1'b0}}, cfg_a[rd_ch]};
      default: reg_rdata = 32'(cnt_a[rd_ch]);
    endcase
  end
endmodule

// File: rtl/dma4_chk.sv
module dma4_chk
  import dma4_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           m_valid,
  input logic           m_ready,
  input logic           m_write,
  input logic [31:0]    m_addr,
  input logic [1:0]     m_size,
  input logic [31:0]    m_wdata,
  input logic [31:0]    m_rdata,
  input logic [NCH-1:0] act
);
  logic rd_hs, wr_hs;
  assign rd_hs = m_valid && m_ready && !m_write;
  assign wr_hs = m_valid && m_ready && m_write;

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hs |=> m_valid && m_write) else $error("write beat missing"); // R2

  AST_WDATA_FROM_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hs |=> m_wdata == ($past(m_rdata) & size_mask(xsize_e'($past(m_size))))) else $error("write data mismatch"); // R3

  AST_SIZE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hs |=> m_size == $past(m_size)) else $error("size changed"); // R3

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_size)) else $error("beat dropped"); // R9

  AST_IDLE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hs |=> !m_valid) else $error("no arbitration gap"); // R7

  AST_ACT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act)) else $error("multiple active channels"); // R7
endmodule

bind dma4_engine dma4_chk #(.NCH(NCH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .m_valid(m_valid),
  .m_ready(m_ready),
  .m_write(m_write),
  .m_addr (m_addr),
  .m_size (m_size),
  .m_wdata(m_wdata),
  .m_rdata(m_rdata),
  .act    (act_w)
);

// File: tb/dma4_engine_test.sv
module dma4_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  int_req = '0;
  logic [1:0]  ext_req = '0;
  logic        m_valid, m_ready, m_write;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0]  m_size;
  logic [3:0]  irq;

  always #4 clk = ~clk;

  dma4_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_req(int_req),
    .ext_req(ext_req), .m_valid(m_valid), .m_ready(m_ready),
    .m_write(m_write), .m_addr(m_addr), .m_size(m_size),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .irq(irq)
  );

  // memory model: 256 bytes, little-endian, right-justified reads
  logic [7:0]  mem [256];
  logic        stall_en = 1'b0;
  int          cyc = 0;
  int          nw = 0, nr = 0;
  logic [7:0]  wlog_a [64];
  logic [31:0] wlog_d [64];
  int          checks = 0, fails = 0;
  bit          finished = 1'b0;

  always @(negedge clk) cyc <= cyc + 1;
  assign m_ready = !stall_en || (cyc % 3 == 0);
  assign m_rdata = {mem[8'(m_addr[7:0] + 8'd3)], mem[8'(m_addr[7:0] + 8'd2)],
                    mem[8'(m_addr[7:0] + 8'd1)], mem[m_addr[7:0]]};

  always @(posedge clk) begin
    if (m_valid && m_ready) begin
      if (m_write) begin
        mem[m_addr[7:0]] <= m_wdata[7:0];
        if (m_size != 2'b00) mem[8'(m_addr[7:0] + 8'd1)] <= m_wdata[15:8];
        if (m_size[1]) begin
          mem[8'(m_addr[7:0] + 8'd2)] <= m_wdata[23:16];
          mem[8'(m_addr[7:0] + 8'd3)] <= m_wdata[31:24];
        end
        wlog_a[nw[5:0]] <= m_addr[7:0];
        wlog_d[nw[5:0]] <= m_wdata;
        nw <= nw + 1;
      end else begin
        nr <= nr + 1;
      end
    end
  end

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7 + 3);
  endfunction

  function automatic logic [31:0] ctl(input bit en, input logic [1:0] sz, input logic [1:0] sm,
                                      input logic [1:0] dm, input bit ie, input bit sw, input bit ext);
    return {22'd0, ext, sw, ie, dm, sm, sz, en};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rwr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_idx = 4'(idx); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rrd(input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_idx = 4'(idx);
    #1 d = reg_rdata;
  endtask

  task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                       input int n, input logic [31:0] c);
    rwr(ch * 4 + 0, s);
    rwr(ch * 4 + 1, d);
    rwr(ch * 4 + 3, n);
    rwr(ch * 4 + 2, c);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int c = 0; c < 4; c++) begin
      rrd(c * 4 + 2, v); chk("R1 ctrl reset", v, 32'h0);
      rrd(c * 4 + 3, v); chk("R1 count reset", v, 32'h0);
    end
    chk("R6 irq reset", 32'(irq), 32'h0);
    chk("R2 bus idle at reset", 32'(m_valid), 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    rwr(0, 32'h1234_5678); rwr(1, 32'h9ABC_DEF0);
    rrd(0, v); chk("R1 ch0 src slot", v, 32'h1234_5678);
    rrd(1, v); chk("R1 ch0 dst slot", v, 32'h9ABC_DEF0);
    rwr(11, 32'h0000_0ABC); rrd(11, v); chk("R1 ch2 count", v, 32'h0000_0ABC);
    rwr(2, ctl(0, 2'b10, 2'b01, 2'b10, 1, 0, 1)); rrd(2, v);
    chk("R1 ch0 ctrl readback", v, ctl(0, 2'b10, 2'b01, 2'b10, 1, 0, 1));
    rwr(10, ctl(0, 2'b01, 2'b00, 2'b00, 0, 0, 1)); rrd(10, v);
    chk("R8 ch2 ext select reads 0", v & 32'h200, 32'h0);
    rwr(2, 32'h0); rwr(10, 32'h0); rwr(11, 32'h0);
  endtask

  task automatic t_word_copy;
    logic [31:0] v;
    int n;
    setup(0, 32'h10, 32'h80, 4, ctl(1, 2'b10, 2'b01, 2'b01, 1, 1, 0));
    n = 0;
    while (!irq[0] && n < 200) begin @(negedge clk); n++; end
    chk("R6 irq after last transfer", 32'(irq[0]), 32'h1);
    for (int k = 0; k < 16; k++) chk("R2 word copy data", 32'(mem[8'h80 + k]), 32'(pat(16 + k)));
    rrd(0, v); chk("R4 src stepped up", v, 32'h20);
    rrd(1, v); chk("R4 dst stepped up", v, 32'h90);
    rrd(3, v); chk("R5 count zero", v, 32'h0);
    rrd(2, v); chk("R5 enable cleared done set", v & 32'h1_0001, 32'h1_0000);
    rwr(2, 32'h1_0080); rrd(2, v);
    chk("R6 done cleared by w1c", v & 32'h1_0000, 32'h0);
    chk("R6 irq low after clear", 32'(irq[0]), 32'h0);
  endtask

  task automatic t_byte_fill;
    logic [31:0] v;
    int w0;
    w0 = nw;
    setup(1, 32'h40, 32'hA3, 3, ctl(1, 2'b00, 2'b00, 2'b10, 0, 1, 0));
    idle(40);
    chk("R2 byte fill beats", 32'(nw - w0), 32'd3);
    for (int k = 1; k <= 3; k++) chk("R4 dst down byte", 32'(mem[8'hA0 + k]), 32'(pat(8'h40)));
    chk("R4 below last untouched", 32'(mem[8'hA0]), 32'(pat(8'hA0)));
    chk("R3 byte wdata upper zero", wlog_d[6'(nw - 1)], 32'(pat(8'h40)));
    rrd(4, v); chk("R4 fixed src", v, 32'h40);
    rrd(5, v); chk("R4 dst after decrement", v, 32'hA0);
    rrd(6, v); chk("R6 done set with ie off", v & 32'h1_0000, 32'h1_0000);
    chk("R6 irq gated by ie", 32'(irq[1]), 32'h0);
    rwr(6, 32'h1_0000);
  endtask

  task automatic t_half_stall;
    logic [31:0] v;
    stall_en = 1'b1;
    setup(1, 32'h50, 32'hC0, 2, ctl(1, 2'b01, 2'b01, 2'b00, 1, 1, 0));
    idle(80);
    chk("R9 half data under stall", {16'd0, mem[8'hC1], mem[8'hC0]}, {16'd0, pat(8'h53), pat(8'h52)});
    chk("R3 half leaves next byte", 32'(mem[8'hC2]), 32'(pat(8'hC2)));
    chk("R3 half wdata upper zero", wlog_d[6'(nw - 1)], {16'd0, pat(8'h53), pat(8'h52)});
    rrd(4, v); chk("R4 src up by two", v, 32'h54);
    rrd(5, v); chk("R4 fixed dst", v, 32'hC0);
    chk("R6 irq ch1", 32'(irq[1]), 32'h1);
    rwr(6, 32'h1_0000);
    stall_en = 1'b0;
  endtask

  task automatic t_priority;
    int w0, r0, n;
    logic [7:0] exp_a [7];
    exp_a = '{8'hF0, 8'hC8, 8'hD0, 8'hD4, 8'hE0, 8'hE4, 8'hF4};
    stall_en = 1'b1;
    w0 = nw;
    setup(0, 32'h00, 32'hC8, 1, ctl(1, 2'b10, 2'b01, 2'b01, 0, 0, 0));
    setup(1, 32'h00, 32'hD0, 2, ctl(1, 2'b10, 2'b01, 2'b01, 0, 0, 0));
    setup(2, 32'h00, 32'hE0, 2, ctl(1, 2'b10, 2'b01, 2'b01, 0, 0, 0));
    setup(3, 32'h10, 32'hF0, 2, ctl(1, 2'b10, 2'b01, 2'b01, 0, 0, 0));
    r0 = nr;
    @(negedge clk); int_req = 4'b1000;
    n = 0;
    while (nr == r0 && n < 100) begin @(negedge clk); n++; end
    int_req = 4'b1111;
    idle(250);
    chk("R7 write count", 32'(nw - w0), 32'd7);
    for (int k = 0; k < 7; k++) chk("R7 service order", 32'(wlog_a[6'(w0 + k)]), 32'(exp_a[k]));
    int_req = 4'b0000;
    stall_en = 1'b0;
    for (int c = 0; c < 4; c++) rwr(c * 4 + 2, 32'h1_0000);
  endtask

  task automatic t_elig;
    logic [31:0] v;
    int w0;
    w0 = nw;
    int_req = 4'b0001; ext_req = 2'b00;
    setup(0, 32'h00, 32'hB0, 1, ctl(1, 2'b00, 2'b01, 2'b01, 0, 0, 1));
    idle(20);
    chk("R8 ext select ignores int_req", 32'(nw - w0), 32'd0);
    rrd(3, v); chk("R8 count held", v, 32'd1);
    ext_req = 2'b01;
    idle(30);
    rrd(3, v); chk("R8 ext request served", v, 32'd0);
    chk("R8 ext data", 32'(mem[8'hB0]), 32'(pat(0)));
    ext_req = 2'b00; int_req = 4'b0100;
    w0 = nw;
    setup(2, 32'h01, 32'hB4, 1, ctl(1, 2'b00, 2'b01, 2'b01, 0, 0, 1));
    idle(30);
    chk("R8 ch2 select ignored", 32'(nw - w0), 32'd1);
    chk("R8 ch2 data", 32'(mem[8'hB4]), 32'(pat(1)));
    rrd(10, v); chk("R8 ch2 select reads 0", v & 32'h200, 32'h0);
    int_req = 4'b0000;
    w0 = nw;
    setup(1, 32'h00, 32'hB8, 0, ctl(1, 2'b00, 2'b01, 2'b01, 0, 1, 0));
    idle(20);
    chk("R8 count zero not eligible", 32'(nw - w0), 32'd0);
    rrd(6, v); chk("R8 enable kept at count zero", v & 32'h1, 32'h1);
    rwr(6, 32'h0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 100000 && !finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_regs();
    t_word_copy();
    t_byte_fill();
    t_half_stall();
    t_priority();
    t_elig();
    finish_run();
  end
endmodule